// File: doc/BRIEF.md
# Embedded Interval, Fixed-Period and Watchdog Timer Unit

This block provides the three timers that an embedded core needs, all paced by a shared time-base tick input. The first is a programmable down-counter that can reload itself and keep running. The second is a fixed-period timer whose period is one of four powers of two. The third is a watchdog. It escalates in stages on successive expiries: a first warning, then an interrupt, then a reset request of a programmable class.

Software sees a control register and a status register. Status bits are cleared by writing ones. A third register holds the reload value of the down-counter and reads back its live count. A bus decoder outside the block produces one-cycle write strobes and a shared write-data word. The interrupt outputs are levels. The three reset outputs are one-cycle request pulses for reset generators outside the block.

The fixed-period and watchdog periods are taken from one free-running tick counter. Each expires when the low bits of that counter wrap. The exponents are parameters: a base exponent and a step for each of the two timers. At their default values the periods are 2^9/2^13/2^17/2^21 and 2^17/2^21/2^25/2^29 ticks.

Top module: `emb_tmr_unit`

## Requirements
- R1: After reset the control and status registers, the reload value and the count read zero, all interrupts and reset pulses are low, and the watchdog is armed.
- R2: A control write stores data bits 31:22 only. Bits 21:0 of the control read-back are zero. Layout: 31:30 watchdog period, 29:28 reset class, 27 watchdog interrupt enable, 26 interval enable, 25:24 fixed period, 23 fixed interrupt enable, 22 auto-reload.
- R3: A free-running counter advances on every tick. The fixed timer expires on a tick where the counter's low FIT_BASE+k*FIT_STEP bits are all ones, with k = control 25:24. An expiry sets status bit 26, and irq_fit equals status 26 AND control 23.
- R4: An interval write loads both the reload value and the count. The counter runs only if the value is above 1 and control 26 is set. While it runs, each tick decrements the count. The count is readable on pit_count and does not change in a cycle without a tick or a write.
- R5: A tick that finds the running count at 1 is an expiry and sets status bit 27. If control 22 and 26 are set and the reload value is above 1, the count reloads. Otherwise it stops at 0.
- R6: irq_pit is a pending flag AND status 27 AND control 26. The flag is set by an expiry and cleared by a status write whose data bit 31 is one.
- R7: While armed, the watchdog expires on a tick where the counter's low WDT_BASE+k*WDT_STEP bits are all ones, with k = control 31:30.
- R8: A watchdog step acts on status 31:30 as held before the cycle. With 00 or 01 it sets status 31. With 10 it sets status 30.
- R9: A step that finds status 31:30 at 11 copies control 29:28 into status 29:28 and disarms the watchdog. It also pulses rst_core, rst_chip or rst_sys for one cycle for class 1, 2 or 3, and pulses none for class 0.
- R10: A status write clears each of bits 31:26 where the data holds a one. A bit that an event sets in the same cycle stays set.
- R11: A control write performs a watchdog step at once, using the new control value, and re-arms unless the step was the final stage. In that cycle the interval counter ignores the tick. It keeps running only if the reload value is above 1 and the new control 26 and 22 are both set, and it restarts from the reload value if its count was 0.
- R12: irq_wdt equals status 30 AND control 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base tick, one cycle per tick |
| ctl_wr | input | 1 | Control register write strobe |
| sts_wr | input | 1 | Status register write-ones-to-clear strobe |
| pit_wr | input | 1 | Interval reload register write strobe |
| wdata | input | 32 | Write data shared by the three strobes |
| ctl_q | output | 32 | Control register read-back |
| sts_q | output | 32 | Status register read-back |
| pit_count | output | PIT_W | Live interval count |
| irq_pit | output | 1 | Interval timer interrupt level |
| irq_fit | output | 1 | Fixed-period timer interrupt level |
| irq_wdt | output | 1 | Watchdog interrupt level |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
The collision of interest is a status clear write that lands on the same clock as a fixed-period expiry. The clear removes the bit and the expiry sets it again. The bench follows its own model of the tick counter and issues the clear on the exact tick where the low counter bits wrap. It then expects status bit 26 to stay set, while the same write a few ticks earlier must clear it. A second collision is a control write that falls on a tick. The watchdog takes one step, not two, and the interval counter skips that tick. Both are judged every clock against a behavioural model of the registers.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;

   // control register, held as bits 31:22 of the bus word
   typedef struct packed {
      logic [1:0] wdt_per;
      logic [1:0] rst_cls;
      logic       wdt_ie;
      logic       pit_en;
      logic [1:0] fit_per;
      logic       fit_ie;
      logic       pit_auto;
   } ctl_t;

   localparam int CTL_LSB = 22;
   localparam int CTL_W   = 10;

   // status register, held as bits 31:26 of the bus word
   localparam int STS_LSB   = 26;
   localparam int STS_W     = 6;
   localparam int S_FIT     = 0;   // bus bit 26
   localparam int S_PIT     = 1;   // bus bit 27
   localparam int S_REC_LO  = 2;   // bus bits 29:28
   localparam int S_WARN    = 4;   // bus bit 30
   localparam int S_FIRST   = 5;   // bus bit 31

   typedef enum logic [1:0] {
      RCLS_NONE = 2'd0,
      RCLS_CORE = 2'd1,
      RCLS_CHIP = 2'd2,
      RCLS_SYS  = 2'd3
   } rst_cls_e;

   localparam int N_PER_SEL = 4;

   function automatic int top_exp(input int base, input int step);
      return base + (N_PER_SEL - 1) * step;
   endfunction

endpackage

// File: rtl/emb_tmr_persel.sv
module emb_tmr_persel #(
   parameter int CNT_W = 21,
   parameter int BASE  = 9,
   parameter int STEP  = 4
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [1:0]       sel,
   input  logic             tick,
   output logic             wrap
);
   import emb_tmr_pkg::*;

   localparam int TOP = top_exp(BASE, STEP);

   if (BASE < 1) begin : g_bad_base
      $error("emb_tmr_persel: BASE must be at least 1");
   end
   if (STEP < 1) begin : g_bad_step
      $error("emb_tmr_persel: STEP must be at least 1");
   end
   if (TOP != CNT_W) begin : g_bad_width
      $error("emb_tmr_persel: CNT_W must equal the largest exponent");
   end

   logic [N_PER_SEL-1:0] hit;

   for (genvar k = 0; k < N_PER_SEL; k++) begin : g_sel
      localparam int EXP = BASE + k * STEP;
      assign hit[k] = &cnt[EXP-1:0];
   end

   assign wrap = tick & hit[sel];

endmodule

// File: rtl/emb_tmr_pit.sv
module emb_tmr_pit #(
   parameter int PIT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [PIT_W-1:0] load_val,
   input  logic             reeval,
   input  logic             en_cur,
   input  logic             auto_cur,
   input  logic             en_new,
   input  logic             auto_new,
   output logic [PIT_W-1:0] count,
   output logic             expire
);
   if (PIT_W < 2) begin : g_bad_w
      $error("emb_tmr_pit: PIT_W must be at least 2");
   end

   localparam logic [PIT_W-1:0] ONE = PIT_W'(1);

   logic [PIT_W-1:0] reload_r;
   logic [PIT_W-1:0] cnt_r;
   logic             run_r;
   logic             reload_ok;
   logic             load_ok;
   logic             keep_new;
   logic             keep_cur;

   assign reload_ok = reload_r > ONE;
   assign load_ok   = load_val > ONE;
   assign keep_new  = reload_ok & en_new & auto_new;
   assign keep_cur  = reload_ok & en_cur & auto_cur;

   // writes take the cycle: a tick in a write cycle is not counted
   assign expire = tick & run_r & (cnt_r == ONE) & ~load & ~reeval;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_r <= '0;
         cnt_r    <= '0;
         run_r    <= 1'b0;
      end else if (load) begin
         reload_r <= load_val;
         cnt_r    <= load_val;
         run_r    <= load_ok & en_cur;
      end else if (reeval) begin
         run_r <= keep_new;
         if (keep_new && cnt_r == '0) begin
            cnt_r <= reload_r;
         end
      end else if (expire) begin
         if (keep_cur) begin
            cnt_r <= reload_r;
         end else begin
            cnt_r <= '0;
            run_r <= 1'b0;
         end
      end else if (tick && run_r) begin
         cnt_r <= cnt_r - ONE;
      end
   end

   assign count = cnt_r;

endmodule

// File: rtl/emb_tmr_wdog.sv
module emb_tmr_wdog (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wrap,
   input  logic       force_step,
   input  logic [1:0] stage,
   input  logic [1:0] cls,
   output logic       set_first,
   output logic       set_warn,
   output logic       set_rec,
   output logic [2:0] rst_req
);
   import emb_tmr_pkg::*;

   logic armed_r;
   logic step;

   assign step = force_step | (wrap & armed_r);

   always_comb begin
      set_first = 1'b0;
      set_warn  = 1'b0;
      set_rec   = 1'b0;
      rst_req   = 3'b000;
      if (step) begin
         case (stage)
            2'b00, 2'b01: set_first = 1'b1;
            2'b10:        set_warn  = 1'b1;
            default: begin
               set_rec = 1'b1;
               case (rst_cls_e'(cls))
                  RCLS_CORE: rst_req = 3'b001;
                  RCLS_CHIP: rst_req = 3'b010;
                  RCLS_SYS:  rst_req = 3'b100;
                  default:   rst_req = 3'b000;
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_r <= 1'b1;
      end else if (step) begin
         armed_r <= (stage != 2'b11);
      end
   end

endmodule

// File: rtl/emb_tmr_unit.sv
module emb_tmr_unit #(
   parameter int PIT_W    = 32,
   parameter int FIT_BASE = 9,
   parameter int FIT_STEP = 4,
   parameter int WDT_BASE = 17,
   parameter int WDT_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_tick,
   input  logic             ctl_wr,
   input  logic             sts_wr,
   input  logic             pit_wr,
   input  logic [31:0]      wdata,
   output logic [31:0]      ctl_q,
   output logic [31:0]      sts_q,
   output logic [PIT_W-1:0] pit_count,
   output logic             irq_pit,
   output logic             irq_fit,
   output logic             irq_wdt,
   output logic             rst_core,
   output logic             rst_chip,
   output logic             rst_sys
);
   import emb_tmr_pkg::*;

   localparam int FIT_TOP = top_exp(FIT_BASE, FIT_STEP);
   localparam int WDT_TOP = top_exp(WDT_BASE, WDT_STEP);
   localparam int TB_W    = (FIT_TOP > WDT_TOP) ? FIT_TOP : WDT_TOP;

   if (PIT_W > 32) begin : g_bad_pit
      $error("emb_tmr_unit: PIT_W cannot exceed the 32-bit data word");
   end
   if (TB_W > 62) begin : g_bad_tb
      $error("emb_tmr_unit: period exponents too large");
   end

   // ---------------- registers ----------------
   ctl_t             ctl_r;
   ctl_t             ctl_wv;
   ctl_t             ctl_use;
   logic [STS_W-1:0] sts_r;
   logic [STS_W-1:0] sts_d;
   logic [TB_W-1:0]  tbc_r;
   logic             pend_r;
   logic [2:0]       rst_r;

   assign ctl_wv  = ctl_t'(wdata[31:CTL_LSB]);
   assign ctl_use = ctl_wr ? ctl_wv : ctl_r;

   // ---------------- shared tick counter ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbc_r <= '0;
      end else if (tb_tick) begin
         tbc_r <= tbc_r + TB_W'(1);
      end
   end

   // ---------------- fixed-period timer ----------------
   logic fit_wrap;

   emb_tmr_persel #(
      .CNT_W (FIT_TOP),
      .BASE  (FIT_BASE),
      .STEP  (FIT_STEP)
   ) u_fit_sel (
      .cnt  (tbc_r[FIT_TOP-1:0]),
      .sel  (ctl_r.fit_per),
      .tick (tb_tick),
      .wrap (fit_wrap)
   );

   // ---------------- interval timer ----------------
   logic pit_exp;

   emb_tmr_pit #(
      .PIT_W (PIT_W)
   ) u_pit (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tb_tick),
      .load     (pit_wr),
      .load_val (wdata[PIT_W-1:0]),
      .reeval   (ctl_wr),
      .en_cur   (ctl_r.pit_en),
      .auto_cur (ctl_r.pit_auto),
      .en_new   (ctl_wv.pit_en),
      .auto_new (ctl_wv.pit_auto),
      .count    (pit_count),
      .expire   (pit_exp)
   );

   // ---------------- watchdog ----------------
   logic       wdt_wrap;
   logic       w_first;
   logic       w_warn;
   logic       w_rec;
   logic [2:0] w_rst;

   emb_tmr_persel #(
      .CNT_W (WDT_TOP),
      .BASE  (WDT_BASE),
      .STEP  (WDT_STEP)
   ) u_wdt_sel (
      .cnt  (tbc_r[WDT_TOP-1:0]),
      .sel  (ctl_r.wdt_per),
      .tick (tb_tick),
      .wrap (wdt_wrap)
   );

   emb_tmr_wdog u_wdog (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrap       (wdt_wrap),
      .force_step (ctl_wr),
      .stage      ({sts_r[S_FIRST], sts_r[S_WARN]}),
      .cls        (ctl_use.rst_cls),
      .set_first  (w_first),
      .set_warn   (w_warn),
      .set_rec    (w_rec),
      .rst_req    (w_rst)
   );

   // ---------------- status merge: clears first, events last ----------------
   always_comb begin
      sts_d = sts_r;
      if (sts_wr) begin
         sts_d = sts_r & ~wdata[31:STS_LSB];
      end
      if (fit_wrap) sts_d[S_FIT]   = 1'b1;
      if (pit_exp)  sts_d[S_PIT]   = 1'b1;
      if (w_first)  sts_d[S_FIRST] = 1'b1;
      if (w_warn)   sts_d[S_WARN]  = 1'b1;
      if (w_rec)    sts_d[S_REC_LO+1:S_REC_LO] = ctl_use.rst_cls;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_r  <= '0;
         sts_r  <= '0;
         pend_r <= 1'b0;
         rst_r  <= 3'b000;
      end else begin
         ctl_r <= ctl_use;
         sts_r <= sts_d;
         rst_r <= w_rst;
         if (pit_exp) begin
            pend_r <= 1'b1;
         end else if (sts_wr && wdata[31]) begin
            pend_r <= 1'b0;
         end
      end
   end

   // ---------------- outputs ----------------
   assign ctl_q    = {ctl_r, {CTL_LSB{1'b0}}};
   assign sts_q    = {sts_r, {STS_LSB{1'b0}}};
   assign irq_fit  = sts_r[S_FIT] & ctl_r.fit_ie;
   assign irq_pit  = pend_r & sts_r[S_PIT] & ctl_r.pit_en;
   assign irq_wdt  = sts_r[S_WARN] & ctl_r.wdt_ie;
   assign rst_core = rst_r[0];
   assign rst_chip = rst_r[1];
   assign rst_sys  = rst_r[2];

endmodule

// File: rtl/emb_tmr_unit_chk.sv
module emb_tmr_unit_chk #(
   parameter int PIT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tb_tick,
   input logic             ctl_wr,
   input logic             sts_wr,
   input logic             pit_wr,
   input logic [31:0]      wdata,
   input logic [31:0]      sts_q,
   input logic [PIT_W-1:0] pit_count,
   input logic             rst_core,
   input logic             rst_chip,
   input logic             rst_sys
);

   AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_wr, sts_wr, pit_wr})); // R11

   AST_PIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pit_wr |=> pit_count == $past(wdata[PIT_W-1:0])); // R4

   AST_PIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tb_tick && !pit_wr && !ctl_wr) |=> pit_count == $past(pit_count)); // R4

   AST_FIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[26]) |-> $past(tb_tick)); // R3

   AST_WDT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[30]) |-> $past(sts_q[31])); // R8

   AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_core, rst_chip, rst_sys})); // R9

   AST_RST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_chip |-> sts_q[29:28] == 2'd2); // R9

   AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && !tb_tick) |=> (sts_q[31:26] & $past(wdata[31:26])) == 6'd0); // R10

endmodule

bind emb_tmr_unit emb_tmr_unit_chk #(.PIT_W(PIT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tb_tick   (tb_tick),
   .ctl_wr    (ctl_wr),
   .sts_wr    (sts_wr),
   .pit_wr    (pit_wr),
   .wdata     (wdata),
   .sts_q     (sts_q),
   .pit_count (pit_count),
   .rst_core  (rst_core),
   .rst_chip  (rst_chip),
   .rst_sys   (rst_sys)
);

// File: tb/test_emb_tmr_unit.sv
module test_emb_tmr_unit;
   localparam int PW  = 16;
   localparam int FB  = 3;
   localparam int FS  = 1;
   localparam int WB  = 5;
   localparam int WS  = 1;
   localparam int TBM = 256;   // 2^max exponent

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tb_tick = 1'b0;
   logic          ctl_wr = 1'b0;
   logic          sts_wr = 1'b0;
   logic          pit_wr = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   ctl_q;
   logic [31:0]   sts_q;
   logic [PW-1:0] pit_count;
   logic          irq_pit, irq_fit, irq_wdt, rst_core, rst_chip, rst_sys;

   always #2 clk = ~clk;   // 250 MHz

   emb_tmr_unit #(.PIT_W(PW), .FIT_BASE(FB), .FIT_STEP(FS),
                  .WDT_BASE(WB), .WDT_STEP(WS)) i_emb_tmr_unit (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .ctl_wr(ctl_wr),
      .sts_wr(sts_wr), .pit_wr(pit_wr), .wdata(wdata), .ctl_q(ctl_q),
      .sts_q(sts_q), .pit_count(pit_count), .irq_pit(irq_pit),
      .irq_fit(irq_fit), .irq_wdt(irq_wdt), .rst_core(rst_core),
      .rst_chip(rst_chip), .rst_sys(rst_sys));

   int n_chk = 0, n_bad = 0, cyc = 0, tick_div = 1;
   int n_core = 0, n_chip = 0, n_sys = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int            m_tbc;
   logic [31:0]   m_ctl, m_sts, nctl, pre;
   logic [PW-1:0] m_rel, m_cnt;
   bit            m_run, m_pend, m_armed, fit_e, pit_e, wdt_s;
   logic [2:0]    m_rst;
   int            fper, wper;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tbc = 0; m_ctl = 0; m_sts = 0; m_rel = 0; m_cnt = 0;
         m_run = 0; m_pend = 0; m_armed = 1; m_rst = 0;
      end else begin
         pre   = m_sts;
         nctl  = ctl_wr ? (wdata & 32'hFFC0_0000) : m_ctl;
         fper  = 1 << (FB + FS * int'(m_ctl[25:24]));
         wper  = 1 << (WB + WS * int'(m_ctl[31:30]));
         fit_e = tb_tick && (m_tbc % fper == fper - 1);
         wdt_s = ctl_wr || (tb_tick && m_armed && (m_tbc % wper == wper - 1));
         pit_e = 0;
         if (pit_wr) begin
            m_rel = wdata[PW-1:0]; m_cnt = m_rel;
            m_run = (m_rel > 1) && m_ctl[26];
         end else if (ctl_wr) begin
            m_run = (m_rel > 1) && nctl[26] && nctl[22];
            if (m_run && m_cnt == 0) m_cnt = m_rel;
         end else if (tb_tick && m_run) begin
            if (m_cnt == 1) begin
               pit_e = 1;
               if (m_ctl[22] && m_ctl[26] && m_rel > 1) m_cnt = m_rel;
               else begin m_cnt = 0; m_run = 0; end
            end else m_cnt = m_cnt - 1;
         end
         if (sts_wr) m_sts = m_sts & ~(wdata & 32'hFC00_0000);
         if (fit_e) m_sts[26] = 1;
         if (pit_e) m_sts[27] = 1;
         m_rst = 0;
         if (wdt_s) begin
            if (pre[31:30] == 2'b11) begin
               m_sts[29:28] = nctl[29:28];
               m_armed = 0;
               if (nctl[29:28] != 0) m_rst[int'(nctl[29:28]) - 1] = 1'b1;
            end else begin
               m_armed = 1;
               if (pre[31:30] == 2'b10) m_sts[30] = 1;
               else m_sts[31] = 1;
            end
         end
         if (pit_e) m_pend = 1;
         else if (sts_wr && wdata[31]) m_pend = 0;
         m_ctl = nctl;
         if (tb_tick) m_tbc = (m_tbc + 1) % TBM;
      end
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (!done) begin
         chk("R2 ctl_q", ctl_q, m_ctl);
         chk("R10 sts_q", sts_q, m_sts);
         chk("R4 pit_count", pit_count, m_cnt);
         chk("R3 irq_fit", irq_fit, m_sts[26] & m_ctl[23]);
         chk("R6 irq_pit", irq_pit, m_pend & m_sts[27] & m_ctl[26]);
         chk("R12 irq_wdt", irq_wdt, m_sts[30] & m_ctl[27]);
         chk("R9 reset pulses", {rst_sys, rst_chip, rst_core}, {m_rst[2], m_rst[1], m_rst[0]});
         n_core += int'(rst_core); n_chip += int'(rst_chip); n_sys += int'(rst_sys);
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input bit c, input bit s, input bit p, input logic [31:0] v);
      @(negedge clk);
      ctl_wr = c; sts_wr = s; pit_wr = p; wdata = v;
      tb_tick = (cyc % tick_div) == 0;
      cyc++;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 32'h0);
   endtask
   task automatic wr_ctl(input logic [31:0] v); drive(1, 0, 0, v); endtask
   task automatic wr_sts(input logic [31:0] v); drive(0, 1, 0, v); endtask
   task automatic wr_pit(input logic [31:0] v); drive(0, 0, 1, v); endtask

   task automatic finish_run;
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 ctl after reset", ctl_q, 32'h0);
      chk("R1 sts after reset", sts_q, 32'h0);
      chk("R1 count after reset", pit_count, 16'h0);
      chk("R1 irqs after reset", {irq_pit, irq_fit, irq_wdt, rst_core, rst_chip, rst_sys}, 6'h0);

      // R2 mask, R11 immediate watchdog step
      wr_ctl(32'hFFFF_FFFF); idle(1);
      chk("R2 control keeps 31:22", ctl_q, 32'hFFC0_0000);
      chk("R11 step on control write", sts_q[31], 1'b1);
      wr_sts(32'hFC00_0000); wr_ctl(32'hC080_0000); wr_sts(32'hFC00_0000);

      // R3 fixed timer, period 8
      idle(40);
      chk("R3 fixed status set", sts_q[26], 1'b1);
      chk("R3 fixed interrupt", irq_fit, 1'b1);

      // R10 plain clear, then clear colliding with an expiry
      while (m_tbc % 8 != 2) idle(1);
      wr_sts(32'h0400_0000); idle(1);
      chk("R10 clear away from expiry", sts_q[26], 1'b0);
      idle(10);
      while (m_tbc % 8 != 6) idle(1);
      wr_sts(32'h0400_0000); idle(1);
      chk("R10 expiry wins over clear", sts_q[26], 1'b1);

      // R3 with sparse ticks and period 32
      tick_div = 2;
      wr_ctl(32'hC280_0000); idle(100);
      tick_div = 1;

      // R4 R5 R6 interval timer with auto-reload
      wr_ctl(32'hC4C0_0000); wr_sts(32'hFC00_0000);
      wr_pit(32'h0000_0005); idle(1);
      chk("R4 load value", pit_count, 16'd5);
      idle(4);
      chk("R4 count down", pit_count, 16'd1);
      chk("R5 no expiry yet", sts_q[27], 1'b0);
      idle(1);
      chk("R5 reload after expiry", pit_count, 16'd5);
      chk("R5 status 27 set", sts_q[27], 1'b1);
      chk("R6 interrupt raised", irq_pit, 1'b1);
      idle(12);
      wr_sts(32'h8000_0000); idle(1);
      chk("R6 bit 31 write drops interrupt", irq_pit, 1'b0);
      chk("R6 status 27 kept", sts_q[27], 1'b1);

      // R4 reload of 1 never runs
      wr_pit(32'h0000_0001); idle(10);
      chk("R4 reload of one holds", pit_count, 16'd1);

      // R11 control without auto-reload stops; R5 single shot
      wr_ctl(32'hC480_0000); wr_sts(32'hFC00_0000);
      wr_pit(32'h0000_0004); idle(8);
      chk("R5 single shot stops at zero", pit_count, 16'd0);
      chk("R5 single shot status", sts_q[27], 1'b1);
      wr_ctl(32'hC4C0_0000); idle(1);
      chk("R11 restart from reload", pit_count, 16'd4);

      // R7 R8 R9 R12 watchdog escalation to a chip reset
      wr_pit(32'h0); wr_sts(32'hFC00_0000);
      n_core = 0; n_chip = 0; n_sys = 0;
      wr_ctl(32'h2800_0000); wr_sts(32'h4000_0000);
      while (m_tbc % 32 != 30) idle(1);
      idle(1);
      chk("R7 no watchdog step before wrap", sts_q[30], 1'b0);
      idle(1);
      chk("R7 watchdog wraps on period", sts_q[30], 1'b1);
      chk("R12 watchdog interrupt", irq_wdt, 1'b1);
      idle(40);
      chk("R9 chip pulse count", n_chip, 64'd1);
      chk("R9 class recorded", sts_q[29:28], 2'd2);
      idle(300);
      chk("R9 disarmed after final stage", n_chip + n_core + n_sys, 64'd1);

      // R8 stage 01 -> first bit, then core reset
      wr_sts(32'h8000_0000);
      wr_ctl(32'h1800_0000); idle(1);
      chk("R8 stage 01 sets bit 31", sts_q[31:30], 2'b11);
      idle(40);
      chk("R9 core pulse count", n_core, 64'd1);

      // R9 system class and no-reset class
      wr_sts(32'hFC00_0000); wr_ctl(32'h3000_0000); idle(80);
      chk("R9 system pulse count", n_sys, 64'd1);
      wr_sts(32'hFC00_0000); wr_ctl(32'h0000_0000); idle(80);
      chk("R9 class zero records zero", sts_q[29:28], 2'd0);
      chk("R9 class zero no pulse", n_core + n_chip + n_sys, 64'd3);

      idle(2);
      finish_run();
   end
endmodule